// File: doc/BRIEF.md
# Station Address ROM Validator

This block reads a byte-serial address ROM through one read port and decides whether the ROM holds a usable station address. After a start request it optionally scans the ROM stream for an eight-byte alignment marker. It then takes six address bytes and a two-byte stored checksum. Over the address it computes a 16-bit sum that doubles and folds with end-around carry. A single done pulse reports the result as ok or fail, and the captured address is presented as one 48-bit word.

The ROM side is a simple pull interface. The block holds `rd_req` high while it wants bytes. A byte is consumed on every rising clock edge where both `rd_req` and `rd_vld` are high. The ROM may stall by holding `rd_vld` low. Byte k of the address appears on `station_addr[8k+7:8k]`.

Top module: `srom_addr_check`

## Requirements
- R1: After reset, `done`, `ok`, `fail` and `rd_req` are low and `station_addr` is zero.
- R2: A start while idle with `skip_sync` low begins a marker search. The search consumes one byte per accepted read and looks for FF,00,55,AA,FF,00,55,AA in consecutive bytes. A byte that does not match the expected marker byte sends the match position back to the first marker byte, and that byte is not tested again as a possible first byte.
- R3: The marker search accepts at most 32 bytes. A marker that completes on the 32nd byte counts as found. Otherwise the run ends with `fail` after exactly 32 reads.
- R4: With `skip_sync` high at start, no marker search occurs and the first byte read is address byte 0.
- R5: After the marker, six address bytes are read and then two checksum bytes, low byte first. Address byte k lands in `station_addr[8k+7:8k]`.
- R6: If bit 0 of address byte 0 is set, the run ends with `fail` right after that byte and no further bytes are read.
- R7: If address bytes 0, 1 and 2 are all zero, the run ends with `fail` after the sixth address byte, and the checksum bytes are not read.
- R8: The checksum uses the little-endian words W0={b1,b0}, W1={b3,b2} and W2={b5,b4}. The sum starts at W0. For each of W1 and W2 in turn, the sum is doubled and reduced by 65535 if it is above 65535. The word is then added, and the sum is reduced by 65535 again if it is above 65535.
- R9: After W2 is added, the reduction is also applied when the sum equals exactly 65535, so that case yields 0.
- R10: `ok` is set only when the computed sum equals the stored checksum. Otherwise `fail` is set. Both flags hold until the next start.
- R11: `done` is a one-cycle pulse with `rd_req` low in that cycle. `station_addr` holds its value until the next start. A start while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a validation run (honoured when idle) |
| skip_sync | input | 1 | Skip the marker search for this run |
| rd_req | output | 1 | Block wants a ROM byte |
| rd_vld | input | 1 | ROM byte on rd_data is valid |
| rd_data | input | 8 | ROM byte |
| station_addr | output | 48 | Captured address, byte 0 in the low bits |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Address and checksum valid |
| fail | output | 1 | Marker, address or checksum rejected |

## Verification
A wrong match position or read counter in the search shows up as a wrong read count at `done`, or as a flipped verdict on the run that ends at the 32-byte boundary. A wrong fold or word order in the checksum is not visible until the last checksum byte is consumed, and it then appears as `ok` and `fail` swapped. The exact-65535 case is needed because no other input exposes the final-fold rule. A position counter error shows at once in `station_addr`, because bytes land in the wrong lanes.

// File: rtl/srom_pkg.sv
package srom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_ADDR,
    ST_SUM
  } srom_state_e;

  localparam logic [16:0] FOLD_VAL = 17'd65535;

  // expected marker byte for a given match position (period of four)
  function automatic logic [7:0] marker_byte(input logic [1:0] pos);
    case (pos)
      2'd0:    return 8'hFF;
      2'd1:    return 8'h00;
      2'd2:    return 8'h55;
      default: return 8'hAA;
    endcase
  endfunction

  function automatic logic [16:0] fold_above(input logic [16:0] v);
    return (v > FOLD_VAL) ? v - FOLD_VAL : v;
  endfunction

  function automatic logic [16:0] fold_atleast(input logic [16:0] v);
    return (v >= FOLD_VAL) ? v - FOLD_VAL : v;
  endfunction

  // one accumulate step: double, fold, add word, fold (final step folds on equality too)
  function automatic logic [16:0] sum_step(input logic [16:0] acc,
                                           input logic [15:0] word,
                                           input logic        last);
    logic [16:0] dbl;
    logic [16:0] tot;
    dbl = fold_above({acc[15:0], 1'b0});
    tot = dbl + {1'b0, word};
    return last ? fold_atleast(tot) : fold_above(tot);
  endfunction

endpackage

// File: rtl/srom_sync_hunt.sv
module srom_sync_hunt #(
  parameter int unsigned LIMIT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       hit,
  output logic       give_up
);
  import srom_pkg::*;

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [2:0]    idx_q;
  logic [CW-1:0] cnt_q;
  logic          byte_match;

  assign byte_match = (byte_in == marker_byte(idx_q[1:0]));
  assign hit        = byte_vld && byte_match && (idx_q == 3'd7);
  assign give_up    = byte_vld && !hit && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (byte_vld) begin
      cnt_q <= cnt_q + 1'b1;
      idx_q <= byte_match ? idx_q + 3'd1 : 3'd0;
    end
  end

  // R3
  hunt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !clear) |-> (cnt_q < CW'(LIMIT)));

endmodule

// File: rtl/srom_cksum.sv
module srom_cksum (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        byte_vld,
  input  logic [2:0]  pos,
  input  logic [7:0]  byte_in,
  output logic [16:0] sum
);
  import srom_pkg::*;

  logic [7:0]  lo_q;
  logic [16:0] sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lo_q  <= '0;
      sum_q <= '0;
    end else if (byte_vld) begin
      if (!pos[0])
        lo_q <= byte_in;
      else if (pos == 3'd1)
        sum_q <= {1'b0, byte_in, lo_q};
      else
        sum_q <= sum_step(sum_q, {byte_in, lo_q}, pos == 3'd5);
    end
  end

  assign sum = sum_q;

  // R8
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q <= FOLD_VAL);

  // R9
  final_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !clear && pos == 3'd5) |=> (sum_q < FOLD_VAL));

endmodule

// File: rtl/srom_addr_check.sv
module srom_addr_check #(
  parameter int unsigned HUNT_LIMIT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        skip_sync,
  output logic        rd_req,
  input  logic        rd_vld,
  input  logic [7:0]  rd_data,
  output logic [47:0] station_addr,
  output logic        done,
  output logic        ok,
  output logic        fail
);
  import srom_pkg::*;

  srom_state_e state_q;
  logic [2:0]  pos_q;
  logic [7:0]  ck_lo_q;
  logic [47:0] addr_q;
  logic        done_q, ok_q, fail_q;

  logic        take, run_clear, hunt_vld, addr_vld;
  logic        sync_hit, sync_give_up;
  logic [16:0] calc_sum;

  assign rd_req    = (state_q != ST_IDLE);
  assign take      = rd_req && rd_vld;
  assign run_clear = (state_q == ST_IDLE) && start;
  assign hunt_vld  = take && (state_q == ST_HUNT);
  assign addr_vld  = take && (state_q == ST_ADDR);

  srom_sync_hunt #(.LIMIT(HUNT_LIMIT)) u_hunt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (run_clear),
    .byte_vld (hunt_vld),
    .byte_in  (rd_data),
    .hit      (sync_hit),
    .give_up  (sync_give_up)
  );

  srom_cksum u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (run_clear),
    .byte_vld (addr_vld),
    .pos      (pos_q),
    .byte_in  (rd_data),
    .sum      (calc_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      ck_lo_q <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= skip_sync ? ST_ADDR : ST_HUNT;
            pos_q   <= '0;
            addr_q  <= '0;
            ok_q    <= 1'b0;
            fail_q  <= 1'b0;
          end
        end
        ST_HUNT: begin
          if (sync_hit) begin
            state_q <= ST_ADDR;
            pos_q   <= '0;
          end else if (sync_give_up) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
          end
        end
        ST_ADDR: begin
          if (addr_vld) begin
            addr_q[{pos_q, 3'b000} +: 8] <= rd_data;
            if (pos_q == 3'd0 && rd_data[0]) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              fail_q  <= 1'b1;
            end else if (pos_q == 3'd5) begin
              if (addr_q[23:0] == 24'd0) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                fail_q  <= 1'b1;
              end else begin
                state_q <= ST_SUM;
                pos_q   <= '0;
              end
            end else begin
              pos_q <= pos_q + 3'd1;
            end
          end
        end
        ST_SUM: begin
          if (take) begin
            if (pos_q == 3'd0) begin
              ck_lo_q <= rd_data;
              pos_q   <= 3'd1;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              ok_q    <= (calc_sum == {1'b0, rd_data, ck_lo_q});
              fail_q  <= (calc_sum != {1'b0, rd_data, ck_lo_q});
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign station_addr = addr_q;
  assign done         = done_q;
  assign ok           = ok_q;
  assign fail         = fail_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> $stable(station_addr));

  // R10
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && fail));

  // R10
  ok_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> done);

endmodule

// File: tb/srom_addr_check_tb.sv
module srom_addr_check_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, skip_sync, rd_vld;
  logic [7:0]  rd_data;
  logic        rd_req, done, ok, fail;
  logic [47:0] station_addr;

  srom_addr_check u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_sync(skip_sync),
    .rd_req(rd_req), .rd_vld(rd_vld), .rd_data(rd_data),
    .station_addr(station_addr), .done(done), .ok(ok), .fail(fail)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] rom [0:63];

  function automatic logic [7:0] rom_at(input int p);
    return (p < 64) ? rom[p] : 8'h11;
  endfunction

  function automatic int ref_sum(input logic [47:0] a);
    int acc;
    acc = int'(a[15:0]);
    for (int i = 1; i < 3; i++) begin
      acc = acc * 2;
      if (acc > 65535) acc = acc - 65535;
      acc = acc + int'(a[16*i +: 16]);
      if ((i == 2 && acc >= 65535) || (i != 2 && acc > 65535)) acc = acc - 65535;
    end
    return acc;
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 64; i++) rom[i] = 8'h11;
  endtask

  task automatic put_marker(input int off);
    for (int i = 0; i < 8; i++)
      case (i % 4) 0: rom[off+i] = 8'hFF; 1: rom[off+i] = 8'h00; 2: rom[off+i] = 8'h55; default: rom[off+i] = 8'hAA; endcase
  endtask

  task automatic put_addr(input int off, input logic [47:0] a, input bit good);
    int s;
    for (int k = 0; k < 6; k++) rom[off+k] = a[8*k +: 8];
    s = ref_sum(a);
    if (!good) s = s ^ 1;
    rom[off+6] = s[7:0];
    rom[off+7] = s[15:8];
  endtask

  task automatic model(input bit skip, output bit eok, output bit efail,
                       output int ereads, output logic [47:0] eaddr);
    int p = 0;
    int m = 0;
    bit synced;
    logic [7:0] b, want;
    int stored;
    eaddr = '0; eok = 0; efail = 1; synced = skip; ereads = 0;
    if (!skip) begin
      for (int n = 0; n < 32; n++) begin
        b = rom_at(p); p++;
        case (m % 4) 0: want = 8'hFF; 1: want = 8'h00; 2: want = 8'h55; default: want = 8'hAA; endcase
        if (b == want) begin
          m++;
          if (m == 8) begin synced = 1; break; end
        end else m = 0;
      end
    end
    if (!synced) begin ereads = p; return; end
    for (int k = 0; k < 6; k++) begin
      eaddr[8*k +: 8] = rom_at(p); p++;
      if (k == 0 && eaddr[0]) begin ereads = p; return; end
    end
    if (eaddr[23:0] == 24'd0) begin ereads = p; return; end
    stored = int'({rom_at(p+1), rom_at(p)});
    p += 2;
    eok = (ref_sum(eaddr) == stored);
    efail = !eok;
    ereads = p;
  endtask

  task automatic run_case(input string tag, input bit skip, input bit mid_start);
    bit eok, efail; int ereads; logic [47:0] eaddr;
    int ptr = 0;
    bit seen = 0;
    model(skip, eok, efail, ereads, eaddr);
    @(negedge clk);
    start = 1'b1; skip_sync = skip;
    @(negedge clk);
    start = 1'b0; skip_sync = ~skip;
    for (int cyc = 0; cyc < 300; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (done) begin seen = 1; break; end
      start   = (mid_start && cyc == 3);
      rd_vld  = ($urandom % 4) != 0;
      rd_data = rom_at(ptr);
      if (rd_req && rd_vld) ptr++;
    end
    start = 1'b0;
    check(tag, "done seen", seen, 1);
    if (!seen) return;
    check(tag, "ok", ok, eok);
    check(tag, "fail", fail, efail);
    check(tag, "bytes read", ptr, ereads);
    check(tag, "station_addr", station_addr, eaddr);
    check("R11", "rd_req at done", rd_req, 0);
    rd_vld = 1'b1;
    @(negedge clk);
    check("R11", "done width", done, 0);
    @(negedge clk);
    check("R11", "addr held", station_addr, eaddr);
    check("R10", "ok held", ok, eok);
    check("R11", "idle no read", rd_req, 0);
    rd_vld = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] a;
    int pre;
    void'($urandom(32'd8211));
    rst_n = 0; start = 0; skip_sync = 0; rd_vld = 0; rd_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "done", done, 0);
    check("R1", "ok", ok, 0);
    check("R1", "fail", fail, 0);
    check("R1", "rd_req", rd_req, 0);
    check("R1", "addr", station_addr, 0);

    // R4 R5 R8: skip, valid address
    clear_rom(); put_addr(0, 48'h6655_4433_2A10, 1); run_case("R4", 1, 0);
    // R2: junk then marker
    clear_rom(); put_marker(5); put_addr(13, 48'hFFEE_DDCC_BB02, 1); run_case("R2", 0, 0);
    // R2: restart without re-test of the breaking byte
    clear_rom(); put_marker(0); rom[7] = 8'hFF; put_marker(8);
    put_addr(16, 48'h1234_5678_9ABC, 1); run_case("R2", 0, 0);
    // R3: marker ends on read 32, then on read 33
    clear_rom(); put_marker(24); put_addr(32, 48'h0102_0304_0506, 1); run_case("R3", 0, 0);
    clear_rom(); put_marker(25); put_addr(33, 48'h0102_0304_0506, 1); run_case("R3", 0, 0);
    // R6: multicast bit
    clear_rom(); put_addr(0, 48'h0A0B_0C0D_0E01, 1); run_case("R6", 1, 0);
    clear_rom(); put_marker(0); put_addr(8, 48'h0A0B_0C0D_0E03, 1); run_case("R6", 0, 0);
    // R7: zero first three bytes
    clear_rom(); put_addr(0, 48'h7788_9900_0000, 1); run_case("R7", 1, 0);
    // R9: pre-fold sum of exactly 65535, stored 0
    clear_rom(); put_addr(0, 48'hFBFF_0000_0100, 1); run_case("R9", 1, 0);
    check("R9", "stored zero", {rom[7], rom[6]}, 0);
    // R10: corrupted checksum
    clear_rom(); put_addr(0, 48'h4455_6677_8800, 0); run_case("R10", 1, 0);
    // R11: start while busy is ignored
    clear_rom(); put_marker(3); put_addr(11, 48'h2468_ACE0_1350, 1); run_case("R11", 0, 1);

    // R8 R10: random cases
    for (int t = 0; t < 40; t++) begin
      bit sk = $urandom % 2;
      clear_rom();
      pre = $urandom % 21;
      for (int i = 0; i < pre; i++) rom[i] = 8'($urandom);
      if (sk) pre = 0; else put_marker(pre);
      a = {16'($urandom), 16'($urandom), 16'($urandom)};
      if (($urandom % 4) != 0) a[0] = 1'b0;
      put_addr(sk ? 0 : pre + 8, a, ($urandom % 4) != 0);
      run_case("R8", sk, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule